// File: doc/BRIEF.md
# Saturating Arithmetic Unit

This execution unit clamps a 32-bit operand into a selectable signed or unsigned range. It has two scalar operations and two packed operations. A scalar operation first shifts the operand by an immediate amount, either left or arithmetically right, and then clamps the shifted value. A packed operation splits the operand into two 16-bit halves, sign-extends each half and clamps each half on its own, then packs the two results back into one word.

Each accepted operation produces a result, an overflow bit for that operation and a sticky saturation bit. The sticky bit collects every overflow until the unit's clear input resets it. Register index 15 on either the source or the destination makes the operation invalid. An arithmetic right shift of zero in a scalar operation is also invalid. An invalid operation is reported through a flag and changes nothing else. All outputs are registered, one cycle after the inputs.

Top module: `sat_unit`

## Requirements
- R1: `valid_o` equals `valid_i` from the previous cycle. When `valid_o` is low, `result_o`, `ovf_o` and `invalid_o` are all 0.
- R2: In the scalar operations, `shift_sel_i`=0 shifts the operand left logically by `shift_amt_i` (0..31), and bits above bit 31 are lost. `shift_sel_i`=1 shifts it right arithmetically by `shift_amt_i` (1..31). The clamp then treats the shifted word as a signed value.
- R3: `op_i`=2'b00 (signed scalar) clamps to N = `sat_fld_i`+1 bits, which gives the range [-2^(N-1), 2^(N-1)-1]. `ovf_o` is 1 exactly when the clamp changes the value.
- R4: `op_i`=2'b01 (unsigned scalar) clamps to N = `sat_fld_i` bits, which gives the range [0, 2^N-1]. A negative value becomes 0 and sets overflow. When N is 0 the result is always 0, and any nonzero value sets overflow.
- R5: `op_i`=2'b10 (signed packed) sign-extends each 16-bit half and clamps it to `sat_fld_i[3:0]`+1 bits. `sat_fld_i[4]`, `shift_sel_i` and `shift_amt_i` have no effect in this operation.
- R6: `op_i`=2'b11 (unsigned packed) clamps each sign-extended half to `sat_fld_i[3:0]` bits.
- R7: In the packed operations, the low half's result goes to bits 15:0 and the high half's result goes to bits 31:16, each cut to 16 bits. `ovf_o` is the OR of the two halves' overflows.
- R8: `sticky_o` is set by every valid operation that has `ovf_o`=1. Only a cycle with `sticky_clr_i`=1 clears it. If a clear and an overflow occur in the same cycle, the overflow wins.
- R9: A valid operation with `src_idx_i`=15 or `dst_idx_i`=15 sets `invalid_o`. In that case `result_o` is 0, `ovf_o` is 0 and `sticky_o` does not change.
- R10: A scalar operation with `shift_sel_i`=1 and `shift_amt_i`=0 is treated like R9. In a packed operation the same field values are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 2 | 00 signed scalar, 01 unsigned scalar, 10 signed packed, 11 unsigned packed |
| shift_sel_i | input | 1 | Scalar pre-shift: 0 left logical, 1 right arithmetic |
| shift_amt_i | input | 5 | Scalar pre-shift amount |
| sat_fld_i | input | 5 | Saturation width field |
| operand_i | input | 32 | Source operand |
| src_idx_i | input | 4 | Source register index |
| dst_idx_i | input | 4 | Destination register index |
| sticky_clr_i | input | 1 | Synchronous clear of the sticky flag |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Saturated result |
| ovf_o | output | 1 | This operation saturated |
| invalid_o | output | 1 | Operation rejected as invalid |
| sticky_o | output | 1 | Sticky saturation flag |

## Verification
The sweep covers every width field with every shift type and amount, and uses operands that sit on each clamp boundary: the most positive value, the most negative value, -1 and 0. An off-by-one error in the width (+1 applied to unsigned, or left off signed) would move every bound and produce a wrong result at nearly every width. Unsigned width 0 and negative unsigned inputs show whether a clamp returns 0 or lets the raw value through. Operands where only one half overflows show whether the halves were swapped or an overflow was dropped. A packed operation carrying a right-shift-by-zero encoding shows whether the invalid check was wrongly applied to packed operations. Clear and overflow in the same cycle, followed by an invalid operation carrying an overflowing operand, show whether the sticky bit has the wrong priority or leaks from a rejected operation.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    OP_SSAT      = 2'b00,
    OP_USAT      = 2'b01,
    OP_SSAT_DUAL = 2'b10,
    OP_USAT_DUAL = 2'b11
  } sat_op_e;

  localparam int unsigned IDX_W   = 4;
  localparam logic [IDX_W-1:0] IDX_BAD = 4'd15;
endpackage

// File: rtl/sat_shift.sv
module sat_shift #(
  parameter int unsigned W     = 32,
  parameter int unsigned AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     data_i,
  input  logic             asr_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     data_o
);
  logic signed [W-1:0] sdata;
  logic [W-1:0]        asr_res;
  logic [W-1:0]        lsl_res;

  always_comb begin
    sdata   = $signed(data_i);
    asr_res = $unsigned(sdata >>> amt_i);
    lsl_res = data_i << amt_i;
    data_o  = asr_i ? asr_res : lsl_res;
  end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int unsigned W   = 32,
  parameter int unsigned N_W = $clog2(W) + 1
) (
  input  logic [W-1:0]   data_i,
  input  logic [N_W-1:0] width_i,
  input  logic           signed_i,
  output logic [W-1:0]   res_o,
  output logic           ovf_o
);
  // two spare bits: holds 2^W and -2^(W-1) without wrap
  localparam int unsigned EW = W + 2;
  localparam logic signed [EW-1:0] ONE = EW'(1);

  logic signed [EW-1:0] x, pw, hi, lo, r;
  logic [N_W-1:0]       sh;

  always_comb begin
    x  = {{2{data_i[W-1]}}, data_i};
    if (signed_i) sh = (width_i == '0) ? '0 : width_i - N_W'(1);
    else          sh = width_i;
    pw = ONE << sh;
    hi = pw - ONE;
    lo = signed_i ? -pw : '0;
    if (x > hi) begin
      r     = hi;
      ovf_o = 1'b1;
    end else if (x < lo) begin
      r     = lo;
      ovf_o = 1'b1;
    end else begin
      r     = x;
      ovf_o = 1'b0;
    end
    res_o = r[W-1:0];
  end
endmodule

// File: rtl/sat_unit.sv
module sat_unit
  import sat_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [1:0]              op_i,
  input  logic                    shift_sel_i,
  input  logic [$clog2(DATA_W)-1:0] shift_amt_i,
  input  logic [$clog2(DATA_W)-1:0] sat_fld_i,
  input  logic [DATA_W-1:0]       operand_i,
  input  logic [IDX_W-1:0]        src_idx_i,
  input  logic [IDX_W-1:0]        dst_idx_i,
  input  logic                    sticky_clr_i,
  output logic                    valid_o,
  output logic [DATA_W-1:0]       result_o,
  output logic                    ovf_o,
  output logic                    invalid_o,
  output logic                    sticky_o
);
  localparam int unsigned AMT_W  = $clog2(DATA_W);
  localparam int unsigned N_W    = AMT_W + 1;
  localparam int unsigned LANE_W = DATA_W / LANES;
  localparam int unsigned DFLD_W = $clog2(LANE_W);

  logic              is_dual, is_signed;
  logic              bad_idx, bad_shift, invalid, fire;
  logic [DATA_W-1:0] shifted, packed_res, res;
  logic [N_W-1:0]    scal_w, dual_w, lane_w;
  logic [LANES-1:0]  lane_ovf;
  logic              ovf_any;

  logic [DATA_W-1:0] lane_in  [LANES];
  logic [DATA_W-1:0] lane_res [LANES];
  logic [LANES-1:0]  lane_raw_ovf;

  always_comb begin
    is_dual   = op_i[1];
    is_signed = ~op_i[0];
    bad_idx   = (src_idx_i == IDX_BAD) || (dst_idx_i == IDX_BAD);
    bad_shift = ~is_dual & shift_sel_i & (shift_amt_i == '0);
    invalid   = bad_idx | bad_shift;
    fire      = valid_i & ~invalid;
    scal_w    = is_signed ? N_W'(sat_fld_i) + N_W'(1) : N_W'(sat_fld_i);
    dual_w    = is_signed ? N_W'(sat_fld_i[DFLD_W-1:0]) + N_W'(1)
                          : N_W'(sat_fld_i[DFLD_W-1:0]);
    lane_w    = is_dual ? dual_w : scal_w;
  end

  sat_shift #(.W(DATA_W), .AMT_W(AMT_W)) u_shift (
    .data_i (operand_i),
    .asr_i  (shift_sel_i),
    .amt_i  (shift_amt_i),
    .data_o (shifted)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] half_ext;
    assign half_ext = {{(DATA_W-LANE_W){operand_i[g*LANE_W+LANE_W-1]}},
                       operand_i[g*LANE_W +: LANE_W]};

    if (g == 0) begin : g_first
      assign lane_in[g]  = is_dual ? half_ext : shifted;
      assign lane_ovf[g] = lane_raw_ovf[g];
    end else begin : g_rest
      assign lane_in[g]  = is_dual ? half_ext : '0;
      assign lane_ovf[g] = lane_raw_ovf[g] & is_dual;
    end

    sat_clamp #(.W(DATA_W), .N_W(N_W)) u_clamp (
      .data_i   (lane_in[g]),
      .width_i  (lane_w),
      .signed_i (is_signed),
      .res_o    (lane_res[g]),
      .ovf_o    (lane_raw_ovf[g])
    );

    assign packed_res[g*LANE_W +: LANE_W] = lane_res[g][LANE_W-1:0];
  end

  assign ovf_any = |lane_ovf;
  assign res     = is_dual ? packed_res : lane_res[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      ovf_o     <= 1'b0;
      invalid_o <= 1'b0;
      sticky_o  <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      result_o  <= fire ? res : '0;
      ovf_o     <= fire & ovf_any;
      invalid_o <= valid_i & invalid;
      // new overflow wins over clear
      sticky_o  <= (sticky_o & ~sticky_clr_i) | (fire & ovf_any);
    end
  end
endmodule

// File: rtl/sat_unit_chk.sv
module sat_unit_chk
  import sat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      valid_i,
  input logic [1:0]                op_i,
  input logic                      shift_sel_i,
  input logic [$clog2(DATA_W)-1:0] shift_amt_i,
  input logic [IDX_W-1:0]          src_idx_i,
  input logic [IDX_W-1:0]          dst_idx_i,
  input logic                      sticky_clr_i,
  input logic                      valid_o,
  input logic [DATA_W-1:0]         result_o,
  input logic                      ovf_o,
  input logic                      invalid_o,
  input logic                      sticky_o
);
  logic bad_idx_in;
  assign bad_idx_in = (src_idx_i == IDX_BAD) || (dst_idx_i == IDX_BAD);

  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (result_o == '0 && !ovf_o && !invalid_o));

  a_r9_index_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bad_idx_in) |=> (invalid_o && result_o == '0 && !ovf_o));

  a_r9_sticky_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bad_idx_in && !sticky_o) |=> !sticky_o);

  a_r10_asr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i[1] && shift_sel_i && shift_amt_i == '0) |=> invalid_o);

  a_r8_sticky_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_o && !sticky_clr_i) |=> sticky_o);

  a_r8_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ovf_o) |-> sticky_o);

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_clr_i |=> (!sticky_o || ovf_o));

  a_r4_unsigned_top_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_USAT) |=> !result_o[DATA_W-1]);
endmodule

bind sat_unit sat_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .op_i         (op_i),
  .shift_sel_i  (shift_sel_i),
  .shift_amt_i  (shift_amt_i),
  .src_idx_i    (src_idx_i),
  .dst_idx_i    (dst_idx_i),
  .sticky_clr_i (sticky_clr_i),
  .valid_o      (valid_o),
  .result_o     (result_o),
  .ovf_o        (ovf_o),
  .invalid_o    (invalid_o),
  .sticky_o     (sticky_o)
);

// File: tb/sim_sat_unit.sv
`timescale 1ns/1ps
module sim_sat_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic        shift_sel_i = 1'b0;
  logic [4:0]  shift_amt_i = '0;
  logic [4:0]  sat_fld_i = '0;
  logic [31:0] operand_i = '0;
  logic [3:0]  src_idx_i = 4'd1;
  logic [3:0]  dst_idx_i = 4'd2;
  logic        sticky_clr_i = 1'b0;
  logic        valid_o, ovf_o, invalid_o, sticky_o;
  logic [31:0] result_o;

  int n_vec = 0;
  int n_bad = 0;
  bit exp_sticky = 1'b0;

  always #2 clk_i = ~clk_i;

  sat_unit u0 (
    .clk_i, .rst_ni, .valid_i, .op_i, .shift_sel_i, .shift_amt_i, .sat_fld_i,
    .operand_i, .src_idx_i, .dst_idx_i, .sticky_clr_i,
    .valid_o, .result_o, .ovf_o, .invalid_o, .sticky_o
  );

  function automatic void ref_sat(input longint v, input int n, input bit s,
                                  output longint r, output bit o);
    longint hi, lo;
    if (s) begin
      hi = (longint'(1) << (n - 1)) - 1;
      lo = -(longint'(1) << (n - 1));
    end else begin
      hi = (longint'(1) << n) - 1;
      lo = 0;
    end
    if (v > hi)      begin r = hi; o = 1'b1; end
    else if (v < lo) begin r = lo; o = 1'b1; end
    else             begin r = v;  o = 1'b0; end
  endfunction

  function automatic void ref_model(input logic [1:0] op, input bit sel,
                                    input logic [4:0] amt, input logic [4:0] fld,
                                    input logic [31:0] x, output logic [31:0] r32,
                                    output bit o, output bit inv);
    logic [31:0] sh;
    longint r0, r1;
    bit o0, o1;
    int n;
    inv = !op[1] && sel && (amt == 0);
    if (!op[1]) begin
      sh = sel ? 32'($signed(x) >>> amt) : (x << amt);
      n  = op[0] ? int'(fld) : int'(fld) + 1;
      ref_sat(longint'($signed(sh)), n, !op[0], r0, o);
      r32 = r0[31:0];
    end else begin
      n = op[0] ? int'(fld[3:0]) : int'(fld[3:0]) + 1;
      ref_sat(longint'($signed(x[15:0])), n, !op[0], r0, o0);
      ref_sat(longint'($signed(x[31:16])), n, !op[0], r1, o1);
      r32 = {r1[15:0], r0[15:0]};
      o = o0 | o1;
    end
  endfunction

  task automatic apply(input bit v, input logic [1:0] op, input bit sel,
                       input logic [4:0] amt, input logic [4:0] fld,
                       input logic [31:0] x, input logic [3:0] src,
                       input logic [3:0] dst, input bit clr, input string tag);
    logic [31:0] r, er;
    bit o, inv, bad, eo, einv;
    valid_i = v; op_i = op; shift_sel_i = sel; shift_amt_i = amt;
    sat_fld_i = fld; operand_i = x; src_idx_i = src; dst_idx_i = dst;
    sticky_clr_i = clr;
    ref_model(op, sel, amt, fld, x, r, o, inv);
    bad  = inv || src == 4'd15 || dst == 4'd15;
    er   = (v && !bad) ? r : 32'h0;
    eo   = v && !bad && o;
    einv = v && bad;
    exp_sticky = (exp_sticky & ~clr) | eo;
    @(negedge clk_i);
    n_vec++;
    if (valid_o !== v || result_o !== er || ovf_o !== eo || invalid_o !== einv
        || sticky_o !== exp_sticky) begin
      n_bad++;
      $display("FAIL %s: op=%0d sel=%0d amt=%0d fld=%0d x=%h got v=%b r=%h o=%b i=%b s=%b exp v=%b r=%h o=%b i=%b s=%b",
               tag, op, sel, amt, fld, x, valid_o, result_o, ovf_o, invalid_o,
               sticky_o, v, er, eo, einv, exp_sticky);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;  3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;  5: return 32'h0000_0100;
      6: return 32'hFFFF_FF00;  7: return 32'h1234_5678;
      8: return 32'hDEAD_BEEF;  9: return 32'h0000_7FFF;
      10: return 32'hFFFF_8000; default: return 32'h4000_0000;
    endcase
  endfunction

  function automatic logic [15:0] half(input int i);
    case (i)
      0: return 16'h0000; 1: return 16'h0001; 2: return 16'h7FFF; 3: return 16'h8000;
      4: return 16'hFFFF; 5: return 16'h00FF; 6: return 16'hFF00; default: return 16'h1234;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_vec++;  // R1 reset state
    if (valid_o !== 1'b0 || result_o !== 32'h0 || sticky_o !== 1'b0 || ovf_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got v=%b r=%h s=%b expected 0 0 0", valid_o, result_o, sticky_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // scalar sweep: R2, R3, R4, R10
    for (int op = 0; op < 2; op++)
      for (int fld = 0; fld < 32; fld++)
        for (int sel = 0; sel < 2; sel++)
          for (int amt = 0; amt < 32; amt++)
            for (int p = 0; p < 12; p++)
              apply(1'b1, 2'(op), sel[0], 5'(amt), 5'(fld), pat(p),
                    4'(p), 4'(amt % 15), 1'b0,
                    (sel == 1 && amt == 0) ? "R10" :
                    (op == 1) ? "R4" : (sel == 0 && amt == 0) ? "R3" : "R2");

    // packed sweep with shift fields set to a scalar-invalid encoding: R5, R6, R10
    for (int op = 2; op < 4; op++)
      for (int fld = 0; fld < 32; fld++)
        for (int h = 0; h < 8; h++)
          for (int l = 0; l < 8; l++)
            apply(1'b1, 2'(op), 1'(l), 5'(l == 0 ? 0 : h), 5'(fld),
                  {half(h), half(l)}, 4'd3, 4'd4, 1'b0, (op == 2) ? "R5" : "R6");

    // R8: clear alone, then clear with overflow, then hold
    apply(1'b0, 2'd0, 1'b0, 5'd0, 5'd7, 32'h0, 4'd1, 4'd2, 1'b1, "R8");
    apply(1'b1, 2'd0, 1'b0, 5'd0, 5'd7, 32'h0000_1000, 4'd1, 4'd2, 1'b1, "R8");
    apply(1'b1, 2'd0, 1'b0, 5'd0, 5'd7, 32'h0000_0003, 4'd1, 4'd2, 1'b0, "R8");
    apply(1'b0, 2'd0, 1'b0, 5'd0, 5'd7, 32'hFFFF_FFFF, 4'd1, 4'd2, 1'b1, "R8");

    // R7: only one half overflows, width 8 signed
    apply(1'b1, 2'd2, 1'b0, 5'd0, 5'd7, 32'h7FFF_0005, 4'd1, 4'd2, 1'b0, "R7");
    apply(1'b0, 2'd0, 1'b0, 5'd0, 5'd0, 32'h0, 4'd1, 4'd2, 1'b1, "R7");
    apply(1'b1, 2'd2, 1'b0, 5'd0, 5'd7, 32'h0005_8000, 4'd1, 4'd2, 1'b0, "R7");
    apply(1'b1, 2'd3, 1'b0, 5'd0, 5'd4, 32'h0003_FFFF, 4'd1, 4'd2, 1'b0, "R7");

    // R9: index 15 with overflowing operand after clear
    apply(1'b0, 2'd0, 1'b0, 5'd0, 5'd0, 32'h0, 4'd1, 4'd2, 1'b1, "R9");
    apply(1'b1, 2'd0, 1'b0, 5'd0, 5'd3, 32'h7FFF_FFFF, 4'd15, 4'd2, 1'b0, "R9");
    apply(1'b1, 2'd1, 1'b0, 5'd0, 5'd0, 32'hFFFF_FFFF, 4'd1, 4'd15, 1'b0, "R9");
    apply(1'b1, 2'd3, 1'b0, 5'd0, 5'd0, 32'h8000_7FFF, 4'd15, 4'd15, 1'b0, "R9");

    // R1: idle cycles with overflowing operand present
    apply(1'b0, 2'd0, 1'b0, 5'd0, 5'd0, 32'h7FFF_FFFF, 4'd1, 4'd2, 1'b0, "R1");
    apply(1'b1, 2'd0, 1'b0, 5'd0, 5'd31, 32'h8000_0000, 4'd1, 4'd2, 1'b0, "R1");
    apply(1'b0, 2'd1, 1'b0, 5'd0, 5'd0, 32'hFFFF_FFFF, 4'd1, 4'd2, 1'b0, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule